// File: doc/BRIEF.md
# TLB Random Replacement Index Generator

This block chooses which translation-buffer entry a random-replacement write lands in. A down-counter steps once per clock through the entries that may be replaced. It starts from the last entry and wraps back there after it reaches the lowest replaceable one. A companion "wired" register holds a floor value. Entries below the floor are reserved and are never offered as a random victim.

Software writes the floor through a write strobe. Only the low six bits of the data word count, and a value past the last entry is clamped to the last entry. Every floor write restarts the counter at the top. The counter itself cannot be written: a write strobe aimed at it has no effect. A read request returns the counter value one cycle later.

Two kinds of entry write are arbitrated here. An indexed write takes its entry from bits 5..0 of a supplied index word. A random write takes the counter value. The chosen entry is presented one cycle after the request, together with a valid flag.

Top module: `tlb_victim_sel`

## Requirements
- R1: During and directly after reset, the floor reads 0, both valid outputs are 0, and the counter holds ENTRIES-1 (47 by default).
- R2: A floor write uses only bits 5..0 of the data word. Bits above bit 5 have no effect.
- R3: A floor value of ENTRIES or more is stored as ENTRIES-1.
- R4: In the cycle after a floor write, the counter equals ENTRIES-1, whatever value it held before.
- R5: When there is no floor write and the counter is above the floor, the counter decreases by exactly one each clock.
- R6: When the counter equals the floor, the next value is ENTRIES-1. The counter is never below the floor.
- R7: Writes aimed at the counter (`rnd_we`, `rnd_wdata`) change nothing at any output.
- R8: A read request in one cycle gives `rnd_rvalid`=1 in the next cycle. `rnd_rdata` then holds the counter value that was present when the request was made.
- R9: A random write request gives `wr_valid`=1 in the next cycle. `wr_idx` then holds the counter value that was present when the request was made.
- R10: An indexed write request gives `wr_valid`=1 in the next cycle. `wr_idx` then holds bits 5..0 of `index_word`.
- R11: When both write requests arrive in the same cycle, the indexed write wins. When neither arrives, `wr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wired_we | input | 1 | Floor register write strobe |
| wired_wdata | input | DATA_W | Floor write data (bits 5..0 used) |
| rnd_we | input | 1 | Write strobe aimed at the counter (ignored) |
| rnd_wdata | input | DATA_W | Data for the ignored counter write |
| rnd_rd | input | 1 | Counter read request |
| index_word | input | DATA_W | Index register value (bits 5..0 used) |
| idx_wr_req | input | 1 | Indexed entry write request |
| rnd_wr_req | input | 1 | Random entry write request |
| wired_o | output | 6 | Current floor value |
| rnd_rvalid | output | 1 | Counter read response valid |
| rnd_rdata | output | 6 | Counter read response |
| wr_valid | output | 1 | Entry write selection valid |
| wr_idx | output | 6 | Entry chosen for the write |

## Verification
Every possible 6-bit floor value, 0 to 63, is written in turn, each time with junk in the upper data bits. This separates correct truncation and clamping from an off-by-one at the size boundary. After each write, the counter is read every cycle for more than two full wraps and compared with a closed-form countdown modulo (ENTRIES - floor). This exposes a wrong restart point, a wrong step, and a wrap that goes too early or too late, including the one-entry span at the clamp value. Random, indexed and simultaneous write requests are mixed with ignored counter writes on a fixed cadence. This distinguishes the source priority and catches any leak of the counter write data.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;
    // Width of the entry-number field; software-visible, so fixed.
    localparam int unsigned FIELD_W = 6;

    typedef logic [FIELD_W-1:0] idx_t;

    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_INDEXED = 2'd1,
        SRC_RANDOM  = 2'd2
    } wr_src_e;

    typedef struct packed {
        logic valid;
        idx_t idx;
    } pick_t;

    typedef struct packed {
        pick_t wr;
        pick_t rd;
    } pick_state_t;
endpackage

// File: rtl/tlbr_wired.sv
module tlbr_wired
    import tlbr_pkg::*;
#(
    parameter int unsigned ENTRIES = 48,
    parameter int unsigned DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output idx_t              wired_o
);
    localparam idx_t TOP_IDX = idx_t'(ENTRIES - 1);

    idx_t wired_d, wired_q;
    idx_t field;
    logic unused_hi;

    assign field     = wdata[FIELD_W-1:0];
    assign unused_hi = ^wdata[DATA_W-1:FIELD_W];

    always_comb begin
        wired_d = wired_q;
        if (we) begin
            wired_d = (32'(field) < ENTRIES) ? field : TOP_IDX;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wired_q <= '0;
        else        wired_q <= wired_d;
    end

    assign wired_o = wired_q;
endmodule

// File: rtl/tlbr_random.sv
module tlbr_random
    import tlbr_pkg::*;
#(
    parameter int unsigned ENTRIES = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  idx_t floor_i,
    output idx_t rnd_o
);
    localparam idx_t TOP_IDX = idx_t'(ENTRIES - 1);

    idx_t rnd_d, rnd_q;

    always_comb begin
        if (restart) begin
            rnd_d = TOP_IDX;
        end else if (rnd_q <= floor_i) begin
            rnd_d = TOP_IDX;
        end else begin
            rnd_d = rnd_q - idx_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rnd_q <= TOP_IDX;
        else        rnd_q <= rnd_d;
    end

    assign rnd_o = rnd_q;
endmodule

// File: rtl/tlbr_pick.sv
module tlbr_pick
    import tlbr_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_req,
    input  logic [DATA_W-1:0] index_word,
    input  logic              rnd_req,
    input  idx_t              rnd_i,
    input  logic              rd_req,
    output logic              wr_valid,
    output idx_t              wr_idx,
    output logic              rd_valid,
    output idx_t              rd_data
);
    pick_state_t st_d, st_q;
    wr_src_e     src;
    logic        unused_hi;

    assign unused_hi = ^index_word[DATA_W-1:FIELD_W];

    always_comb begin
        if (idx_req)      src = SRC_INDEXED;
        else if (rnd_req) src = SRC_RANDOM;
        else              src = SRC_NONE;
    end

    always_comb begin
        st_d = st_q;
        unique case (src)
            SRC_INDEXED: st_d.wr = '{valid: 1'b1, idx: index_word[FIELD_W-1:0]};
            SRC_RANDOM:  st_d.wr = '{valid: 1'b1, idx: rnd_i};
            default:     st_d.wr = '{valid: 1'b0, idx: st_q.wr.idx};
        endcase
        st_d.rd.valid = rd_req;
        if (rd_req) st_d.rd.idx = rnd_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_valid = st_q.wr.valid;
    assign wr_idx   = st_q.wr.idx;
    assign rd_valid = st_q.rd.valid;
    assign rd_data  = st_q.rd.idx;
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
    import tlbr_pkg::*;
#(
    parameter int unsigned ENTRIES = 48,
    parameter int unsigned DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wired_we,
    input  logic [DATA_W-1:0] wired_wdata,
    input  logic              rnd_we,
    input  logic [DATA_W-1:0] rnd_wdata,
    input  logic              rnd_rd,
    input  logic [DATA_W-1:0] index_word,
    input  logic              idx_wr_req,
    input  logic              rnd_wr_req,
    output logic [5:0]        wired_o,
    output logic              rnd_rvalid,
    output logic [5:0]        rnd_rdata,
    output logic              wr_valid,
    output logic [5:0]        wr_idx
);
    idx_t wired_val;
    idx_t rnd_val;
    logic unused_rnd_write;

    // The counter is read-only: its write port is accepted and dropped.
    assign unused_rnd_write = ^{rnd_we, rnd_wdata};

    tlbr_wired #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_wired (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wired_we),
        .wdata   (wired_wdata),
        .wired_o (wired_val)
    );

    tlbr_random #(.ENTRIES(ENTRIES)) u_random (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wired_we),
        .floor_i (wired_val),
        .rnd_o   (rnd_val)
    );

    tlbr_pick #(.DATA_W(DATA_W)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_req    (idx_wr_req),
        .index_word (index_word),
        .rnd_req    (rnd_wr_req),
        .rnd_i      (rnd_val),
        .rd_req     (rnd_rd),
        .wr_valid   (wr_valid),
        .wr_idx     (wr_idx),
        .rd_valid   (rnd_rvalid),
        .rd_data    (rnd_rdata)
    );

    assign wired_o = wired_val;
endmodule

// File: rtl/tlbr_checker.sv
module tlbr_checker #(
    parameter int unsigned ENTRIES = 48
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wired_we,
    input logic       idx_wr_req,
    input logic       rnd_wr_req,
    input logic       rnd_rd,
    input logic [5:0] wired_q,
    input logic [5:0] random_q,
    input logic       wr_valid,
    input logic [5:0] wr_idx,
    input logic       rnd_rvalid,
    input logic [5:0] rnd_rdata
);
    localparam logic [5:0] TOP_IDX = 6'(ENTRIES - 1);

    p_reset_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (random_q == TOP_IDX && wired_q == 6'd0));

    p_wired_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wired_q <= TOP_IDX);

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wired_we)) |-> random_q == TOP_IDX);

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wired_we) && $past(random_q) > $past(wired_q))
        |-> random_q == $past(random_q) - 6'd1);

    p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        random_q >= wired_q);

    p_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rnd_rd)) |-> (rnd_rvalid && rnd_rdata == $past(random_q)));

    p_pick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rnd_wr_req) && !$past(idx_wr_req))
        |-> (wr_valid && wr_idx == $past(random_q)));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rnd_wr_req) && !$past(idx_wr_req)) |-> !wr_valid);
endmodule

bind tlb_victim_sel tlbr_checker #(.ENTRIES(ENTRIES)) u_tlbr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wired_we   (wired_we),
    .idx_wr_req (idx_wr_req),
    .rnd_wr_req (rnd_wr_req),
    .rnd_rd     (rnd_rd),
    .wired_q    (wired_val),
    .random_q   (rnd_val),
    .wr_valid   (wr_valid),
    .wr_idx     (wr_idx),
    .rnd_rvalid (rnd_rvalid),
    .rnd_rdata  (rnd_rdata)
);

// File: tb/tlb_victim_sel_bench.sv
module tlb_victim_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 48;
    localparam int DATA_W     = 64;
    localparam int TOP        = ENTRIES - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wired_we = 1'b0;
    logic [DATA_W-1:0] wired_wdata = '0;
    logic              rnd_we = 1'b0;
    logic [DATA_W-1:0] rnd_wdata = '0;
    logic              rnd_rd = 1'b0;
    logic [DATA_W-1:0] index_word = '0;
    logic              idx_wr_req = 1'b0;
    logic              rnd_wr_req = 1'b0;
    logic [5:0]        wired_o;
    logic              rnd_rvalid;
    logic [5:0]        rnd_rdata;
    logic              wr_valid;
    logic [5:0]        wr_idx;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_victim_sel #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_tlb_victim_sel (
        .clk(clk), .rst_n(rst_n),
        .wired_we(wired_we), .wired_wdata(wired_wdata),
        .rnd_we(rnd_we), .rnd_wdata(rnd_wdata),
        .rnd_rd(rnd_rd), .index_word(index_word),
        .idx_wr_req(idx_wr_req), .rnd_wr_req(rnd_wr_req),
        .wired_o(wired_o), .rnd_rvalid(rnd_rvalid), .rnd_rdata(rnd_rdata),
        .wr_valid(wr_valid), .wr_idx(wr_idx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected counter value n edges after the edge that wrote floor w.
    function automatic int exp_rnd(input int w, input int n);
        int f    = (w < ENTRIES) ? w : TOP;
        int span = ENTRIES - f;
        return TOP - (n % span);
    endfunction

    task automatic sweep(input int w);
        int  f = (w < ENTRIES) ? w : TOP;
        int  span = ENTRIES - f;
        int  last = 2 * span + 3;
        bit  pend_idx = 0;
        bit  pend_rnd = 0;
        int  exp_i = 0;
        @(negedge clk);
        wired_we    = 1'b1;
        wired_wdata = {32'hA5C3_0F96, 26'h2AB_CDEF, 6'(w)};
        rnd_rd      = 1'b1;
        idx_wr_req  = 1'b0;
        rnd_wr_req  = 1'b0;
        @(posedge clk);
        for (int n = 0; n <= last; n++) begin
            @(negedge clk);
            wired_we = 1'b0;
            if (n == 0) begin
                check(wired_o == 6'(f), (w < ENTRIES) ? "R2 floor low bits" : "R3 floor clamp",
                      int'(wired_o), f);
            end else begin
                check(rnd_rvalid == 1'b1, "R8 read valid", int'(rnd_rvalid), 1);
                check(int'(rnd_rdata) == exp_rnd(w, n - 1),
                      (n == 1) ? "R4 restart" :
                      (((n - 2) % span) == span - 1) ? "R6 wrap at floor" : "R5 count down / R7 write ignored",
                      int'(rnd_rdata), exp_rnd(w, n - 1));
                check(int'(rnd_rdata) >= f, "R6 never below floor", int'(rnd_rdata), f);
            end
            if (pend_idx || pend_rnd) begin
                check(wr_valid == 1'b1, "R9 R10 write valid", int'(wr_valid), 1);
                check(int'(wr_idx) == exp_i,
                      (pend_idx && pend_rnd) ? "R11 indexed wins" :
                      pend_idx ? "R10 indexed entry" : "R9 random entry",
                      int'(wr_idx), exp_i);
            end else if (n > 0) begin
                check(wr_valid == 1'b0, "R11 no request no valid", int'(wr_valid), 0);
            end
            // Drive the next requests.
            rnd_we     = (n % 2) == 1;
            rnd_wdata  = 64'(n * 37 + 5);
            pend_rnd   = (n < last) && ((n % 3) == 0);
            pend_idx   = (n < last) && ((n % 5) == 0);
            rnd_wr_req = pend_rnd;
            idx_wr_req = pend_idx;
            index_word = {32'hFFFF_0000, 26'h3FF_FFFF, 6'((n * 7 + w) % 64)};
            if (pend_idx)      exp_i = (n * 7 + w) % 64;
            else if (pend_rnd) exp_i = exp_rnd(w, n);
            @(posedge clk);
        end
        rnd_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        check(wired_o == 6'd0, "R1 reset floor", int'(wired_o), 0);
        check(rnd_rvalid == 1'b0, "R1 reset read valid", int'(rnd_rvalid), 0);
        check(wr_valid == 1'b0, "R1 reset write valid", int'(wr_valid), 0);
        rst_n  = 1'b1;
        rnd_rd = 1'b1;
        @(negedge clk);
        check(int'(rnd_rdata) == TOP, "R1 reset counter top", int'(rnd_rdata), TOP);
        @(negedge clk);
        check(int'(rnd_rdata) == TOP - 1, "R5 first step after reset", int'(rnd_rdata), TOP - 1);
        for (int w = 0; w < 64; w++) sweep(w);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule